// File: doc/BRIEF.md
# Configurable LUT logic slice

This block is a behavioural model of one programmable fabric cell. Two halves each pair a 4-input lookup table with a storage element. Every function the cell computes comes from configuration bits, not fixed gates: both truth tables, the wide-function combination of the two tables, whether storage is edge- or level-triggered, whether set/reset acts at once or at the clock, and the polarity of the enable and control inputs.

Configuration enters through a one-bit serial port, one bit per clock while the shift enable is high. The port has no back-pressure, so a bit is taken on every such cycle. Each half drives a combinational output and a stored copy of it, and both are valid at the same time. A separate ripple carry path adds two 2-bit operands taken from the low LUT input pins, plus a carry-in. It does not pass through the tables.

Top module: `lut_slice`

## Requirements
- R1: Configuration is 37 bits, shifted in one per rising edge while `cfg_en` is high. The first 16 bits are the F table with entry 0 first, the next 16 are the G table with entry 0 first, and the last 5 are the mode bits, bit 0 first.
- R2: When mode bit 0 (wide select) is 0, `x` equals F-table entry number `f_in`. In every mode, `y` equals G-table entry number `g_in`.
- R3: When mode bit 0 is 1, `x` equals the G output if `sel5` is 1 and the F output if `sel5` is 0. This lets one slice realise any 5-input function.
- R4: In flip-flop mode (mode bit 1 = 0), `xq`/`yq` load `x`/`y` on a rising edge when the effective enable is 1 and hold otherwise. The effective enable is `ce` XOR mode bit 3.
- R5: In latch mode (mode bit 1 = 1), the stored value follows its input while `clk` is high and the effective enable is 1, and it holds while `clk` is low.
- R6: With mode bit 2 = 0, set and reset act only at a rising edge. An active reset clears the storage, an active set makes it 1, and reset wins when both are active.
- R7: With mode bit 2 = 1, an active reset clears `xq` and `yq` at once, without waiting for a clock edge.
- R8: When mode bit 4 is 1, `set_in` and `rst_in` are active low. When it is 0, they are active high.
- R9: `{cout, sum}` equals `{g_in[1],g_in[0]} + {f_in[1],f_in[0]} + cin`, whatever the configuration.
- R10: While `cfg_en` is high, flip-flop storage in synchronous-control mode keeps its value.
- R11: While `rst_n` is low, the configuration and the storage are cleared, so `x`, `y`, `xq` and `yq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the gate of latch-mode storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_bit | input | 1 | Serial configuration data |
| f_in | input | 4 | F table index; bits 1:0 are carry operand A |
| g_in | input | 4 | G table index; bits 1:0 are carry operand B |
| sel5 | input | 1 | Fifth input of the wide multiplexer |
| ce | input | 1 | Clock enable, polarity set by configuration |
| set_in | input | 1 | Set control, polarity set by configuration |
| rst_in | input | 1 | Reset control, polarity set by configuration |
| cin | input | 1 | Carry input |
| x | output | 1 | Combinational output of the F half |
| y | output | 1 | Combinational output of the G half |
| xq | output | 1 | Stored output of the F half |
| yq | output | 1 | Stored output of the G half |
| sum | output | 2 | Carry-path sum |
| cout | output | 1 | Carry-path carry-out |

## Verification
The bench builds the slice with its default 4-input tables and 2-bit carry path. At that size, each test can reload the full 37-bit chain, and each table vector can pick any of the 16 entries and compare the F and G halves directly. The small carry width keeps the carry-out reachable from a few operand pairs. The small chain also makes latch timing, the immediate and clocked control styles, and the hold during shifting quick to exercise, one configuration after another.

// File: rtl/slice_pkg.sv
package slice_pkg;
  typedef struct packed {
    logic sr_invert;   // bit 4
    logic ce_invert;   // bit 3
    logic sr_async;    // bit 2
    logic latch_mode;  // bit 1
    logic wide_sel;    // bit 0
  } slice_mode_t;

  localparam int MODE_W = $bits(slice_mode_t);
  localparam int HALVES = 2;
endpackage

// File: rtl/slice_cfg_chain.sv
module slice_cfg_chain
  import slice_pkg::*;
#(
  parameter int TABLE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               shift_bit,
  output logic [TABLE_W-1:0] f_tab,
  output logic [TABLE_W-1:0] g_tab,
  output slice_mode_t        mode
);
  localparam int CHAIN_W = 2 * TABLE_W + MODE_W;

  logic [CHAIN_W-1:0] chain_q;

  // New bits enter at the top; the first bit shifted ends at position 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chain_q <= '0;
    else if (shift_en) chain_q <= {shift_bit, chain_q[CHAIN_W-1:1]};
  end

  assign f_tab = chain_q[TABLE_W-1:0];
  assign g_tab = chain_q[2*TABLE_W-1:TABLE_W];
  assign mode  = slice_mode_t'(chain_q[CHAIN_W-1:2*TABLE_W]);
endmodule

// File: rtl/slice_lut.sv
module slice_lut #(
  parameter int K = 4
) (
  input  logic [(1<<K)-1:0] table_bits,
  input  logic [K-1:0]      idx,
  output logic              o
);
  assign o = table_bits[idx];
endmodule

// File: rtl/slice_store.sv
module slice_store
  import slice_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hold,
  input  logic        d,
  input  logic        ce,
  input  logic        set_in,
  input  logic        rst_in,
  input  slice_mode_t mode,
  output logic        q
);
  logic ce_eff, set_eff, rst_eff;
  logic a_clr, a_set;
  logic ff_q, lat_q;

  assign ce_eff  = ce ^ mode.ce_invert;
  assign set_eff = set_in ^ mode.sr_invert;
  assign rst_eff = rst_in ^ mode.sr_invert;

  // Immediate controls: global reset always, user controls only when configured so.
  assign a_clr = ~rst_n | (mode.sr_async & rst_eff);
  assign a_set = mode.sr_async & set_eff & ~a_clr;

  always_ff @(posedge clk or posedge a_clr or posedge a_set) begin
    if (a_clr)      ff_q <= 1'b0;
    else if (a_set) ff_q <= 1'b1;
    else if (!hold) begin
      if (!mode.sr_async && rst_eff)      ff_q <= 1'b0;
      else if (!mode.sr_async && set_eff) ff_q <= 1'b1;
      else if (ce_eff)                    ff_q <= d;
    end
  end

  always_latch begin
    if (a_clr)      lat_q <= 1'b0;
    else if (a_set) lat_q <= 1'b1;
    else if (clk && !hold) begin
      if (!mode.sr_async && rst_eff)      lat_q <= 1'b0;
      else if (!mode.sr_async && set_eff) lat_q <= 1'b1;
      else if (ce_eff)                    lat_q <= d;
    end
  end

  assign q = mode.latch_mode ? lat_q : ff_q;
endmodule

// File: rtl/slice_carry.sv
module slice_carry #(
  parameter int W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] c;

  assign c[0] = cin;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]  = a[i] ^ b[i] ^ c[i];
    assign c[i+1]  = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
  end
  assign cout = c[W];
endmodule

// File: rtl/lut_slice.sv
module lut_slice
  import slice_pkg::*;
#(
  parameter int LUT_K   = 4,
  parameter int CARRY_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic               cfg_bit,
  input  logic [LUT_K-1:0]   f_in,
  input  logic [LUT_K-1:0]   g_in,
  input  logic               sel5,
  input  logic               ce,
  input  logic               set_in,
  input  logic               rst_in,
  input  logic               cin,
  output logic               x,
  output logic               y,
  output logic               xq,
  output logic               yq,
  output logic [CARRY_W-1:0] sum,
  output logic               cout
);
  localparam int TABLE_W = 1 << LUT_K;

  logic [TABLE_W-1:0] f_tab, g_tab;
  slice_mode_t        mode_q;

  logic [HALVES-1:0][TABLE_W-1:0] tabs;
  logic [HALVES-1:0][LUT_K-1:0]   idxs;
  logic [HALVES-1:0]              lut_o;
  logic [HALVES-1:0]              half_d;
  logic [HALVES-1:0]              half_q;

  slice_cfg_chain #(.TABLE_W(TABLE_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_en),
    .shift_bit(cfg_bit),
    .f_tab    (f_tab),
    .g_tab    (g_tab),
    .mode     (mode_q)
  );

  assign tabs = {g_tab, f_tab};
  assign idxs = {g_in, f_in};

  // Wide-function stage: the fifth input picks between the two tables.
  assign half_d[0] = mode_q.wide_sel ? (sel5 ? lut_o[1] : lut_o[0]) : lut_o[0];
  assign half_d[1] = lut_o[1];

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    slice_lut #(.K(LUT_K)) u_lut (
      .table_bits(tabs[h]),
      .idx       (idxs[h]),
      .o         (lut_o[h])
    );
    slice_store u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (cfg_en),
      .d     (half_d[h]),
      .ce    (ce),
      .set_in(set_in),
      .rst_in(rst_in),
      .mode  (mode_q),
      .q     (half_q[h])
    );
  end

  slice_carry #(.W(CARRY_W)) u_carry (
    .a   (f_in[CARRY_W-1:0]),
    .b   (g_in[CARRY_W-1:0]),
    .cin (cin),
    .sum (sum),
    .cout(cout)
  );

  assign x  = half_d[0];
  assign y  = half_d[1];
  assign xq = half_q[0];
  assign yq = half_q[1];
endmodule

// File: rtl/lut_slice_checker.sv
module lut_slice_checker
  import slice_pkg::*;
#(
  parameter int LUT_K   = 4,
  parameter int CARRY_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_en,
  input logic [LUT_K-1:0]   f_in,
  input logic [LUT_K-1:0]   g_in,
  input logic               ce,
  input logic               set_in,
  input logic               rst_in,
  input logic               cin,
  input logic               x,
  input logic               xq,
  input logic               yq,
  input logic [CARRY_W-1:0] sum,
  input logic               cout,
  input slice_mode_t        mode_q
);
  logic sync_ff, rst_act, set_act, ce_act;
  assign sync_ff = !mode_q.sr_async && !mode_q.latch_mode;
  assign rst_act = rst_in ^ mode_q.sr_invert;
  assign set_act = set_in ^ mode_q.sr_invert;
  assign ce_act  = ce ^ mode_q.ce_invert;

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en && sync_ff |=> mode_q.sr_async || mode_q.latch_mode || ($stable(xq) && $stable(yq)));

  p_reset_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en && sync_ff && rst_act |=> !xq && !yq);

  p_async_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en && mode_q.sr_async && !mode_q.latch_mode && rst_act |-> !xq && !yq);

  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en && sync_ff && !rst_act && !set_act && ce_act |=> xq == $past(x));

  p_ce_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en && sync_ff && !rst_act && !set_act && !ce_act |=> $stable(xq) && $stable(yq));

  p_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    {cout, sum} == (CARRY_W+1)'(f_in[CARRY_W-1:0]) + (CARRY_W+1)'(g_in[CARRY_W-1:0]) + (CARRY_W+1)'(cin));
endmodule

bind lut_slice lut_slice_checker #(.LUT_K(LUT_K), .CARRY_W(CARRY_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cfg_en(cfg_en),
  .f_in  (f_in),
  .g_in  (g_in),
  .ce    (ce),
  .set_in(set_in),
  .rst_in(rst_in),
  .cin   (cin),
  .x     (x),
  .xq    (xq),
  .yq    (yq),
  .sum   (sum),
  .cout  (cout),
  .mode_q(mode_q)
);

// File: tb/lut_slice_bench.sv
module lut_slice_bench;
  localparam int LUT_K   = 4;
  localparam int CARRY_W = 2;
  localparam int TW      = 1 << LUT_K;
  localparam int CHAIN   = 2 * TW + 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_bit = 1'b0;
  logic [LUT_K-1:0] f_in = '0, g_in = '0;
  logic sel5 = 1'b0, ce = 1'b0, set_in = 1'b0, rst_in = 1'b0, cin = 1'b0;
  logic x, y, xq, yq, cout;
  logic [CARRY_W-1:0] sum;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  lut_slice #(.LUT_K(LUT_K), .CARRY_W(CARRY_W)) u_lut_slice (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .f_in(f_in), .g_in(g_in), .sel5(sel5), .ce(ce), .set_in(set_in),
    .rst_in(rst_in), .cin(cin), .x(x), .y(y), .xq(xq), .yq(yq),
    .sum(sum), .cout(cout)
  );

  // {ftab, gtab, mode, f_in, g_in, sel5, cin, exp_x, exp_y, exp_sum, exp_cout}
  localparam logic [51:0] VEC [0:7] = '{
    {16'h8000, 16'h6996, 5'd0, 4'hF, 4'h3, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 1'b1},
    {16'h8000, 16'h6996, 5'd0, 4'hE, 4'h7, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 1'b1},
    {16'hFFFE, 16'h0001, 5'd0, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0},
    {16'h8000, 16'hFFFE, 5'd1, 4'hF, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 1'b0},
    {16'h8000, 16'hFFFE, 5'd1, 4'hF, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0},
    {16'h0000, 16'hFFFF, 5'd1, 4'h5, 4'hA, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1},
    {16'h1234, 16'hABCD, 5'd0, 4'h2, 4'hC, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0},
    {16'h1234, 16'hABCD, 5'd0, 4'hD, 4'hF, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 1'b1}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_cfg(input logic [TW-1:0] ft, input logic [TW-1:0] gt, input logic [4:0] md);
    for (int i = 0; i < CHAIN; i++) begin
      @(negedge clk);
      cfg_en  = 1'b1;
      cfg_bit = (i < TW) ? ft[i] : (i < 2*TW) ? gt[i-TW] : md[i-2*TW];
    end
    @(negedge clk);
    cfg_en  = 1'b0;
    cfg_bit = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic held;
    // R11: reset state
    f_in = 4'hF; g_in = 4'hF;
    repeat (3) @(negedge clk);
    #1;
    check("R11 x,y,xq,yq during reset", {4'b0, x, y, xq, yq}, 8'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R3 R9 table walk, stored copy through R4
    for (int v = 0; v < 8; v++) begin
      logic [51:0] e;
      e = VEC[v];
      ce = 1'b0;
      load_cfg(e[51:36], e[35:20], e[19:15]);
      f_in = e[14:11]; g_in = e[10:7]; sel5 = e[6]; cin = e[5];
      #1;
      check($sformatf("R1 R2 R3 x vec%0d", v), {7'b0, x}, {7'b0, e[4]});
      check($sformatf("R1 R2 y vec%0d", v), {7'b0, y}, {7'b0, e[3]});
      check($sformatf("R9 carry vec%0d", v), {5'b0, cout, sum}, {5'b0, e[0], e[2:1]});
      ce = 1'b1;
      step();
      check($sformatf("R4 xq,yq vec%0d", v), {6'b0, xq, yq}, {6'b0, e[4], e[3]});
    end

    // R4: enable gating and its inversion
    ce = 1'b0; f_in = 4'h0; g_in = 4'h0; sel5 = 1'b0;
    load_cfg(16'hFFFF, 16'h0000, 5'b00000);
    step();
    step();
    check("R4 hold with ce low", {7'b0, xq}, 8'h0);
    ce = 1'b1;
    step();
    check("R4 load with ce high", {7'b0, xq}, 8'h1);
    load_cfg(16'h0000, 16'h0000, 5'b01000);
    step();
    check("R4 inverted ce high holds", {7'b0, xq}, 8'h1);
    ce = 1'b0;
    step();
    check("R4 inverted ce low loads", {7'b0, xq}, 8'h0);

    // R6: clocked set/reset, reset wins
    ce = 1'b1;
    load_cfg(16'hFFFF, 16'h0000, 5'b00000);
    step();
    check("R6 preload xq,yq", {6'b0, xq, yq}, 8'h2);
    set_in = 1'b1; rst_in = 1'b1;
    #1;
    check("R6 no effect before edge", {7'b0, xq}, 8'h1);
    step();
    check("R6 reset wins over set", {6'b0, xq, yq}, 8'h0);
    rst_in = 1'b0;
    step();
    check("R6 set alone", {6'b0, xq, yq}, 8'h3);
    set_in = 1'b0;

    // R7: immediate reset
    load_cfg(16'hFFFF, 16'hFFFF, 5'b00100);
    step();
    check("R7 preload", {6'b0, xq, yq}, 8'h3);
    rst_in = 1'b1;
    #1;
    check("R7 clears without edge", {6'b0, xq, yq}, 8'h0);
    #2;
    rst_in = 1'b0;
    #1;
    check("R7 stays clear until edge", {6'b0, xq, yq}, 8'h0);
    step();
    check("R7 reloads after release", {6'b0, xq, yq}, 8'h3);

    // R8: inverted set/reset polarity
    set_in = 1'b1; rst_in = 1'b1;
    load_cfg(16'hFFFF, 16'h0000, 5'b10000);
    step();
    check("R8 high levels inactive", {6'b0, xq, yq}, 8'h2);
    rst_in = 1'b0;
    step();
    check("R8 low reset active", {6'b0, xq, yq}, 8'h0);
    set_in = 1'b0; rst_in = 1'b0;

    // R5: latch transparency and hold
    load_cfg(16'hAAAA, 16'h0000, 5'b00010);
    f_in = 4'h0;
    step();
    @(posedge clk);
    #2 f_in = 4'h1;
    #1;
    check("R5 transparent while clk high", {7'b0, xq}, 8'h1);
    @(negedge clk);
    f_in = 4'h0;
    #1;
    check("R5 holds while clk low", {7'b0, xq}, 8'h1);
    @(posedge clk);
    #1;
    check("R5 follows again when clk high", {7'b0, xq}, 8'h0);

    // R10: storage held during shifting
    load_cfg(16'hFFFF, 16'h0000, 5'b00000);
    step();
    check("R10 preload", {7'b0, xq}, 8'h1);
    held = 1'b1;
    for (int i = 0; i < CHAIN; i++) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_bit = 1'b0;
      #1;
      if (xq !== 1'b1) held = 1'b0;
    end
    @(negedge clk);
    cfg_en = 1'b0;
    #1;
    check("R10 xq held while cfg_en high", {7'b0, held}, 8'h1);
    step();
    check("R10 new table loads after shifting", {7'b0, xq}, 8'h0);

    // R11: reset in mid-run clears configuration and storage
    load_cfg(16'hFFFF, 16'hFFFF, 5'b00000);
    step();
    check("R11 preload", {6'b0, x, xq}, 8'h3);
    rst_n = 1'b0;
    #1;
    check("R11 mid-run reset clears", {4'b0, x, y, xq, yq}, 8'h0);
    @(negedge clk);
    rst_n = 1'b1;

    finish_run();
  end
endmodule